// File: doc/BRIEF.md
# Single-Error-Correcting Protected Data Register

This block is an 8-bit storage register for a processor data path, such as an accumulator, a program-counter byte or an instruction latch. It holds its contents so that one upset bit does not corrupt them. Each write passes through a Hamming encoder, and the 12-bit codeword is stored: 8 data bits plus 4 check bits, all in flip-flops. The stored image is decoded and repaired combinationally on every read, so the consumer sees corrected data in the same cycle. No access takes longer than it would on an unprotected register.

A non-zero syndrome raises an error flag in the same cycle. With scrubbing enabled, the repaired codeword is written back on the next clock edge. A test port XORs a mask into the stored codeword to inject upsets. Data enters through a plain write strobe, and reads are continuous, so the block has no valid/ready handshake. A register accepts a write in every cycle and has nothing to hold back.

Top module: `sec_guard_reg`

## Requirements
- R1: After reset the stored codeword is all zeros. This is the codeword of data 0x00. `rd_data` is 0x00, `err_flag` is 0 and `syndrome` is 0.
- R2: When `wr_en` is high at a rising edge, the codeword of `wr_data` is stored. From that edge on, `rd_data` equals the written byte and `err_flag` is 0.
- R3: Codeword layout: bit p-1 of `raw_code` holds Hamming position p (1..12). Check bits sit at positions 1, 2, 4 and 8. Data bits 0..7 fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. Each check bit at position 2^c makes the XOR of all positions whose index has bit c set equal to 0 (even parity).
- R4: With exactly one bit of the stored codeword flipped, `rd_data` still equals the last written byte in the same cycle, with no added clock.
- R5: `syndrome` is the XOR of the indices of all set positions in the stored codeword. With a single flip it equals the flipped position. `err_flag` is high exactly when `syndrome` is non-zero.
- R6: When `inj_en` is high at a rising edge and `wr_en` is low, the stored codeword becomes its old value XOR `inj_mask`. Bit p-1 of the mask targets position p.
- R7: When `scrub_en` and `err_flag` are high at a rising edge, with `wr_en` and `inj_en` low, the corrected codeword is stored. For a single flip this clears `err_flag` and leaves `rd_data` unchanged.
- R8: With `scrub_en` high and no error, or with all controls low, the stored codeword does not change.
- R9: `wr_en` has priority over `inj_en` and scrub, and its edge stores only the new codeword. `inj_en` has priority over scrub, and scrub makes no change on that edge.
- R10: Two flipped bits in the stored codeword always raise `err_flag`. A syndrome above 12 flips no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store `wr_data` at the next edge |
| wr_data | input | 8 | Byte to write |
| scrub_en | input | 1 | Allow write-back of the corrected codeword |
| inj_en | input | 1 | Apply `inj_mask` at the next edge |
| inj_mask | input | 12 | Bits XORed into the stored codeword |
| rd_data | output | 8 | Corrected read data |
| err_flag | output | 1 | Non-zero syndrome on the stored codeword |
| syndrome | output | 4 | Syndrome of the stored codeword |
| raw_code | output | 12 | Stored codeword before correction |

## Verification
Three functions can claim the same edge: a write, an injection and a scrub of an error already present. The bench first plants a single flip. It then drives `wr_en` or `inj_en` together with `scrub_en` in one cycle and compares `raw_code` after that edge with a codeword computed from the R3 layout. Write-over-scrub is judged by a clean new codeword. Inject-over-scrub is judged by the old flip and the new one both remaining, which raises `err_flag` as a two-bit upset.

// File: rtl/sec_pkg.sv
package sec_pkg;
  localparam int DATA_W = 8;

  function automatic int chk_bits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  localparam int CHK_W = chk_bits(DATA_W);
  localparam int CW_W  = DATA_W + CHK_W;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CHK_W-1:0]  syn_t;
  typedef logic [CW_W-1:0]   code_t;

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // place data bits at non-power-of-two positions, then fill parity
  function automatic code_t sec_encode(input data_t d);
    code_t cw;
    int k;
    logic par;
    cw = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_pow2(p)) begin
        cw[p-1] = d[k];
        k++;
      end
    end
    for (int c = 0; c < CHK_W; c++) begin
      par = 1'b0;
      for (int p = 1; p <= CW_W; p++)
        if (((p >> c) & 1) == 1) par = par ^ cw[p-1];
      cw[(1 << c) - 1] = par;
    end
    return cw;
  endfunction

  function automatic syn_t sec_syndrome(input code_t cw);
    syn_t s;
    s = '0;
    for (int p = 1; p <= CW_W; p++)
      if (cw[p-1]) s = s ^ CHK_W'(p);
    return s;
  endfunction

  function automatic data_t sec_extract(input code_t cw);
    data_t d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_pow2(p)) begin
        d[k] = cw[p-1];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/sec_encoder.sv
module sec_encoder
  import sec_pkg::*;
(
  input  data_t data_in,
  output code_t code_out
);
  always_comb code_out = sec_encode(data_in);
endmodule

// File: rtl/sec_decoder.sv
module sec_decoder
  import sec_pkg::*;
(
  input  code_t code_in,
  output code_t code_fixed,
  output data_t data_out,
  output syn_t  syn_out,
  output logic  err_out
);
  syn_t  syn;
  code_t flip;

  always_comb syn = sec_syndrome(code_in);

  // one comparator per position picks the bit to repair
  for (genvar p = 1; p <= CW_W; p++) begin : g_flip
    assign flip[p-1] = (syn == CHK_W'(p));
  end

  assign code_fixed = code_in ^ flip;
  assign data_out   = sec_extract(code_fixed);
  assign syn_out    = syn;
  assign err_out    = |syn;
endmodule

// File: rtl/sec_store.sv
module sec_store
  import sec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  code_t wr_code,
  input  logic  inj_en,
  input  code_t inj_mask,
  input  logic  scrub_go,
  input  code_t fixed_code,
  output code_t code_q
);
  localparam code_t RESET_CODE = sec_encode('0);

  code_t code_d;

  // priority: write, then injection, then scrub
  always_comb begin
    code_d = code_q;
    if (wr_en)         code_d = wr_code;
    else if (inj_en)   code_d = code_q ^ inj_mask;
    else if (scrub_go) code_d = fixed_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= RESET_CODE;
    else        code_q <= code_d;
  end
endmodule

// File: rtl/sec_guard_reg.sv
module sec_guard_reg
  import sec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              scrub_en,
  input  logic              inj_en,
  input  logic [CW_W-1:0]   inj_mask,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_flag,
  output logic [CHK_W-1:0]  syndrome,
  output logic [CW_W-1:0]   raw_code
);
  code_t enc_code;
  code_t code_q;
  code_t fixed_code;
  logic  dec_err;

  sec_encoder i_enc (
    .data_in (wr_data),
    .code_out(enc_code)
  );

  sec_store i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_code   (enc_code),
    .inj_en    (inj_en),
    .inj_mask  (inj_mask),
    .scrub_go  (scrub_en & dec_err),
    .fixed_code(fixed_code),
    .code_q    (code_q)
  );

  sec_decoder i_dec (
    .code_in   (code_q),
    .code_fixed(fixed_code),
    .data_out  (rd_data),
    .syn_out   (syndrome),
    .err_out   (dec_err)
  );

  assign err_flag = dec_err;
  assign raw_code = code_q;
endmodule

// File: rtl/sec_guard_chk.sv
module sec_guard_chk
  import sec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              scrub_en,
  input logic              inj_en,
  input logic [CW_W-1:0]   inj_mask,
  input logic [DATA_W-1:0] rd_data,
  input logic              err_flag,
  input logic [CHK_W-1:0]  syndrome,
  input logic [CW_W-1:0]   raw_code
);
  a_r2_write_reads_back: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == $past(wr_data)) && !err_flag);

  a_r4_single_flip_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en && !wr_en && !err_flag && $countones(inj_mask) == 1)
      |=> err_flag && (rd_data == $past(rd_data)));

  a_r7_scrub_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (scrub_en && err_flag && !wr_en && !inj_en && int'(syndrome) <= CW_W)
      |=> !err_flag && (rd_data == $past(rd_data)));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !inj_en && !(scrub_en && err_flag)) |=> $stable(raw_code));

  a_r10_double_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en && !wr_en && !err_flag && $countones(inj_mask) == 2) |=> err_flag);
endmodule

bind sec_guard_reg sec_guard_chk i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .scrub_en(scrub_en),
  .inj_en  (inj_en),
  .inj_mask(inj_mask),
  .rd_data (rd_data),
  .err_flag(err_flag),
  .syndrome(syndrome),
  .raw_code(raw_code)
);

// File: tb/test_sec_guard_reg.sv
`timescale 1ns/100ps
module test_sec_guard_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        scrub_en = 1'b0;
  logic        inj_en = 1'b0;
  logic [11:0] inj_mask = '0;
  logic [7:0]  rd_data;
  logic        err_flag;
  logic [3:0]  syndrome;
  logic [11:0] raw_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sec_guard_reg i_sec_guard_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .scrub_en(scrub_en), .inj_en(inj_en), .inj_mask(inj_mask),
    .rd_data(rd_data), .err_flag(err_flag), .syndrome(syndrome),
    .raw_code(raw_code)
  );

  // independent encoder from the R3 layout
  function automatic logic [11:0] ref_code(input logic [7:0] d);
    logic [11:0] c;
    c = '0;
    c[2] = d[0]; c[4] = d[1]; c[5] = d[2]; c[6] = d[3];
    c[8] = d[4]; c[9] = d[5]; c[10] = d[6]; c[11] = d[7];
    c[0] = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c[1] = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c[3] = d[1] ^ d[2] ^ d[3] ^ d[7];
    c[7] = d[4] ^ d[5] ^ d[6] ^ d[7];
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive one cycle of controls, then release them after the edge
  task automatic step(input bit we, input logic [7:0] d, input bit ie,
                      input logic [11:0] m, input bit se);
    @(negedge clk);
    wr_en = we; wr_data = d; inj_en = ie; inj_mask = m; scrub_en = se;
    @(negedge clk);
    wr_en = 1'b0; inj_en = 1'b0; scrub_en = 1'b0; inj_mask = '0;
  endtask

  task automatic t_reset();
    check(raw_code == 12'h000, "R1 raw", raw_code, 0);
    check(rd_data == 8'h00, "R1 data", rd_data, 0);
    check(!err_flag && syndrome == 0, "R1 err", {err_flag, syndrome}, 0);
  endtask

  task automatic t_write(input logic [7:0] d);
    step(1'b1, d, 1'b0, '0, 1'b0);
    check(rd_data == d, "R2 read", rd_data, d);
    check(!err_flag, "R2 err", err_flag, 0);
    check(raw_code == ref_code(d), "R3 layout", raw_code, ref_code(d));
  endtask

  task automatic t_single_flips(input logic [7:0] d);
    for (int p = 1; p <= 12; p++) begin
      step(1'b1, d, 1'b0, '0, 1'b0);
      step(1'b0, 8'h00, 1'b1, 12'(1 << (p - 1)), 1'b0);
      check(raw_code == (ref_code(d) ^ 12'(1 << (p - 1))), "R6 inject",
            raw_code, ref_code(d) ^ 12'(1 << (p - 1)));
      check(rd_data == d, "R4 corrected", rd_data, d);
      check(err_flag && syndrome == 4'(p), "R5 syndrome", syndrome, p);
    end
  endtask

  task automatic t_scrub();
    step(1'b1, 8'h5A, 1'b0, '0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 12'h040, 1'b0);
    step(1'b0, 8'h00, 1'b0, '0, 1'b1);
    check(raw_code == ref_code(8'h5A), "R7 scrub raw", raw_code, ref_code(8'h5A));
    check(!err_flag && rd_data == 8'h5A, "R7 scrub clean", rd_data, 8'h5A);
    // hold with no scrub and an error present
    step(1'b0, 8'h00, 1'b1, 12'h800, 1'b0);
    step(1'b0, 8'h00, 1'b0, '0, 1'b0);
    check(raw_code == (ref_code(8'h5A) ^ 12'h800), "R8 idle hold",
          raw_code, ref_code(8'h5A) ^ 12'h800);
  endtask

  task automatic t_scrub_idle();
    step(1'b1, 8'hC3, 1'b0, '0, 1'b0);
    step(1'b0, 8'h00, 1'b0, '0, 1'b1);
    check(raw_code == ref_code(8'hC3), "R8 scrub no error", raw_code, ref_code(8'hC3));
  endtask

  task automatic t_priority();
    step(1'b1, 8'h11, 1'b0, '0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 12'h004, 1'b0);
    step(1'b1, 8'h96, 1'b0, '0, 1'b1);
    check(raw_code == ref_code(8'h96), "R9 write over scrub", raw_code, ref_code(8'h96));
    step(1'b1, 8'h2B, 1'b1, 12'h0F0, 1'b0);
    check(raw_code == ref_code(8'h2B), "R9 write over inject", raw_code, ref_code(8'h2B));
    step(1'b0, 8'h00, 1'b1, 12'h004, 1'b0);
    step(1'b0, 8'h00, 1'b1, 12'h010, 1'b1);
    check(raw_code == (ref_code(8'h2B) ^ 12'h014), "R9 inject over scrub",
          raw_code, ref_code(8'h2B) ^ 12'h014);
    check(err_flag, "R10 double after priority", err_flag, 1);
  endtask

  task automatic t_double();
    step(1'b1, 8'h77, 1'b0, '0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 12'h011, 1'b0);
    check(err_flag && syndrome == 4'd4, "R10 double flag", syndrome, 4);
    // positions 6 and 9 give syndrome 15, beyond the word: no repair
    step(1'b1, 8'h77, 1'b0, '0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 12'h120, 1'b0);
    step(1'b0, 8'h00, 1'b0, '0, 1'b1);
    check(raw_code == (ref_code(8'h77) ^ 12'h120), "R10 no repair above 12",
          raw_code, ref_code(8'h77) ^ 12'h120);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(8'hA5);
    t_write(8'hFF);
    t_write(8'h00);
    t_write(8'h3C);
    t_single_flips(8'hA5);
    t_single_flips(8'h00);
    t_scrub();
    t_scrub_idle();
    t_priority();
    t_double();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule